// File: doc/BRIEF.md
# Deep-Sleep Entry and Wake Sequencer

This block controls when a small processor system drops into its deepest clock-stopped state and how it climbs back out. The processor raises a one-cycle sleep request. If the deep-sleep select input is low at that moment, the block gives an ordinary light sleep, with no change to the regulator, the flash or the main clock. If the select is high, the block starts a deep-stop entry. That entry waits for any flash program operation and any peripheral-bus transfer to finish. The block then samples two mode bits, one for low-power regulator mode and one for flash power-down, drives the matching power controls and gates the main clock.

A wake event starts a timed recovery made of up to three phases, each a parameterised cycle count. The regulator recovery phase runs only after low-power regulator mode. The flash wake phase runs only after flash power-down. The oscillator startup phase always runs. At the end the clock is released and a one-cycle pulse marks the return to run. A keep-running output for the independent watchdog latches once the watchdog is started and survives every power state until reset.

Top module: `stop_sequencer`

## Requirements
- R1: During and right after reset, `state_o` is 00 (run) and `clk_gate`, `reg_lp_en`, `flash_pd_en`, `light_sleep`, `wdg_run` and `run_pulse` are all 0.
- R2: A `sleep_req` in run with `deep_sel` low sets `light_sleep` at the next edge. `state_o` stays 00 and `clk_gate`, `reg_lp_en` and `flash_pd_en` stay 0. The first `wake_evt` clears `light_sleep` at the next edge.
- R3: A `sleep_req` in run with `deep_sel` high moves `state_o` to 01 (entry pending) at the next edge. The block stays in 01 on every edge where `flash_busy` or `bus_busy` is 1. It moves to 10 (stopped) on the first edge where both are 0 and `wake_evt` is 0.
- R4: While `state_o` is 10, `clk_gate` is 1, `reg_lp_en` equals the sampled regulator bit and `flash_pd_en` equals the sampled flash bit.
- R5: `cfg_lp_reg` and `cfg_flash_pd` are sampled only on the edge that moves the block from 01 to 10. Changing them while stopped or waking changes neither the outputs nor the wake latency.
- R6: A `wake_evt` while stopped moves `state_o` to 11 (waking) at the next edge. The block stays in 11 for exactly (lp ? REG_CYC : 0) + (pd ? FLASH_CYC : 0) + OSC_CYC cycles, then returns to 00 with `run_pulse` high for exactly one cycle.
- R7: During waking, `reg_lp_en` is 0 and `clk_gate` is 1. When both mode bits were sampled as 1, `flash_pd_en` stays 1 for the first REG_CYC waking cycles (regulator phase first) and is 0 afterwards.
- R8: A `wake_evt` while in 01 cancels the entry. `state_o` returns to 00 at the next edge, with no `run_pulse` and no clock gating.
- R9: A one-cycle `wdg_start` sets `wdg_run` at the next edge. `wdg_run` then stays 1 through every state until `rst_n` is driven low.
- R10: `wake_evt` in run outside light sleep has no effect on any output. `sleep_req` while pending, stopped or waking has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | One-cycle sleep request from the processor |
| deep_sel | input | 1 | 1 selects deep stop, 0 selects light sleep |
| cfg_lp_reg | input | 1 | Put regulator in low-power mode during stop |
| cfg_flash_pd | input | 1 | Power down flash during stop |
| flash_busy | input | 1 | Flash program operation in progress |
| bus_busy | input | 1 | Peripheral-bus transfer outstanding |
| wake_evt | input | 1 | Wake event |
| wdg_start | input | 1 | One-cycle start of the independent watchdog |
| clk_gate | output | 1 | 1 gates the main clock |
| reg_lp_en | output | 1 | Regulator low-power enable |
| flash_pd_en | output | 1 | Flash power-down enable |
| light_sleep | output | 1 | Ordinary sleep active |
| wdg_run | output | 1 | Watchdog keep-running enable |
| state_o | output | 2 | 00 run, 01 entry pending, 10 stopped, 11 waking |
| run_pulse | output | 1 | One-cycle pulse on return to run after waking |

## Verification
The assertions check on every cycle the relations that hold at any single edge. Pending stays pending while flash or the bus is busy, stopped always gates the clock, and the power controls do not move while stopped. Waking keeps the regulator at full power, a cancel returns to run without a pulse, and the watchdog enable never falls. Only the bench scenarios show the wake latency of each of the four mode combinations, the order of the regulator and flash phases, and that mode bits changed after entry are ignored. The bench also checks light sleep, the reset values, and a reset clearing the watchdog enable.

// File: rtl/stop_seq_pkg.sv
// Shared types for the deep-sleep sequencer.
// Assumes: state codes are visible on the status port and must stay fixed.
package stop_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_PEND = 2'b01,
        ST_STOP = 2'b10,
        ST_WAKE = 2'b11
    } pm_state_t;

    typedef enum logic [1:0] {
        PH_REG   = 2'b00,
        PH_FLASH = 2'b01,
        PH_OSC   = 2'b10
    } wake_phase_t;

endpackage

// File: rtl/stop_wake_timer.sv
// Wake-up phase timer.
// Runs the regulator, flash and oscillator phases in that order and skips
// the first two when they are not enabled. Each phase is a down-counter
// loaded from its own parameter.
// Assumes: all phase lengths are at least 1, and use_reg and use_flash stay
// stable while busy.
module stop_wake_timer
    import stop_seq_pkg::*;
#(
    parameter int REG_CYC   = 5,
    parameter int FLASH_CYC = 7,
    parameter int OSC_CYC   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        use_reg,
    input  logic        use_flash,
    output logic        busy,
    output logic        done,
    output wake_phase_t phase
);

    localparam int MAX_A  = (REG_CYC > FLASH_CYC) ? REG_CYC : FLASH_CYC;
    localparam int MAX_C  = (MAX_A > OSC_CYC) ? MAX_A : OSC_CYC;
    localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    logic [CW-1:0] cnt_q;
    wake_phase_t   first_ph;
    wake_phase_t   next_ph;

    // Reload value for a phase: its length minus one.
    function automatic logic [CW-1:0] reload(input wake_phase_t ph);
        case (ph)
            PH_REG:   reload = CW'(REG_CYC - 1);
            PH_FLASH: reload = CW'(FLASH_CYC - 1);
            default:  reload = CW'(OSC_CYC - 1);
        endcase
    endfunction

    // Pick the first phase that applies to this wake-up.
    always_comb begin
        if (use_reg)        first_ph = PH_REG;
        else if (use_flash) first_ph = PH_FLASH;
        else                first_ph = PH_OSC;
    end

    // Pick the phase that follows the current one.
    always_comb begin
        if (phase == PH_REG && use_flash) next_ph = PH_FLASH;
        else                              next_ph = PH_OSC;
    end

    // Phase sequencing and the down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= PH_OSC;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            phase <= first_ph;
            cnt_q <= reload(first_ph);
        end else if (busy) begin
            if (cnt_q == '0) begin
                if (phase == PH_OSC) begin
                    busy <= 1'b0;
                end else begin
                    phase <= next_ph;
                    cnt_q <= reload(next_ph);
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // The last cycle of the oscillator phase ends the sequence.
    assign done = busy && (phase == PH_OSC) && (cnt_q == '0);

endmodule

// File: rtl/stop_wdg_keep.sv
// Sticky keep-running enable for the independent watchdog.
// Once started it stays set through all power states. Only reset clears it.
// Assumes: start is a synchronous pulse.
module stop_wdg_keep (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run
);

    // Set on start, clear only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     run <= 1'b0;
        else if (start) run <= 1'b1;
    end

endmodule

// File: rtl/stop_sequencer.sv
// Deep-sleep entry and wake sequencer (top).
// Handles light sleep and deep stop entry. Entry is held off while flash
// programming or a bus transfer is pending. Mode bits are sampled at entry,
// the power controls are driven while stopped, and the wake phases are timed.
// Assumes: sleep_req, wake_evt and wdg_start are synchronous to clk.
module stop_sequencer
    import stop_seq_pkg::*;
#(
    parameter int REG_CYC   = 5,
    parameter int FLASH_CYC = 7,
    parameter int OSC_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       deep_sel,
    input  logic       cfg_lp_reg,
    input  logic       cfg_flash_pd,
    input  logic       flash_busy,
    input  logic       bus_busy,
    input  logic       wake_evt,
    input  logic       wdg_start,
    output logic       clk_gate,
    output logic       reg_lp_en,
    output logic       flash_pd_en,
    output logic       light_sleep,
    output logic       wdg_run,
    output logic [1:0] state_o,
    output logic       run_pulse
);

    pm_state_t   state_q, state_d;
    logic        lp_q, pd_q;
    logic        entry_clear;
    logic        tmr_start, tmr_busy, tmr_done;
    wake_phase_t tmr_phase;

    // Entry may proceed only when nothing is outstanding.
    assign entry_clear = !flash_busy && !bus_busy;
    assign tmr_start   = (state_q == ST_STOP) && wake_evt;

    // Next-state selection for the power-mode sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:  if (sleep_req && deep_sel && !light_sleep) state_d = ST_PEND;
            ST_PEND: if (wake_evt)         state_d = ST_RUN;
                     else if (entry_clear) state_d = ST_STOP;
            ST_STOP: if (wake_evt)         state_d = ST_WAKE;
            ST_WAKE: if (tmr_done)         state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register and return-to-run pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            run_pulse <= 1'b0;
        end else begin
            state_q   <= state_d;
            run_pulse <= (state_q == ST_WAKE) && tmr_done;
        end
    end

    // Sample the mode bits on the edge where the stop actually begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q <= 1'b0;
            pd_q <= 1'b0;
        end else if (state_q == ST_PEND && !wake_evt && entry_clear) begin
            lp_q <= cfg_lp_reg;
            pd_q <= cfg_flash_pd;
        end
    end

    // Light sleep: set by a plain request, cleared by any wake event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            light_sleep <= 1'b0;
        else if (light_sleep && wake_evt)
            light_sleep <= 1'b0;
        else if (state_q == ST_RUN && sleep_req && !deep_sel)
            light_sleep <= 1'b1;
    end

    stop_wake_timer #(
        .REG_CYC   (REG_CYC),
        .FLASH_CYC (FLASH_CYC),
        .OSC_CYC   (OSC_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tmr_start),
        .use_reg   (lp_q),
        .use_flash (pd_q),
        .busy      (tmr_busy),
        .done      (tmr_done),
        .phase     (tmr_phase)
    );

    stop_wdg_keep u_wdg (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wdg_start),
        .run   (wdg_run)
    );

    // Power controls: the flash stays down until the regulator phase ends.
    assign clk_gate    = (state_q == ST_STOP) || (state_q == ST_WAKE);
    assign reg_lp_en   = (state_q == ST_STOP) && lp_q;
    assign flash_pd_en = pd_q && ((state_q == ST_STOP) ||
                         ((state_q == ST_WAKE) && tmr_busy && tmr_phase == PH_REG));
    assign state_o     = state_q;

endmodule

// File: rtl/stop_sequencer_chk.sv
// Property checker for stop_sequencer, attached by bind.
// Assumes: the state codes defined in stop_seq_pkg.
module stop_sequencer_chk
    import stop_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       flash_busy,
    input logic       bus_busy,
    input logic       wake_evt,
    input logic       clk_gate,
    input logic       reg_lp_en,
    input logic       flash_pd_en,
    input logic       light_sleep,
    input logic       wdg_run,
    input logic [1:0] state_o,
    input logic       run_pulse
);

    // R2: light sleep never touches clock or power controls.
    assert_light_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        light_sleep |-> (!clk_gate && !reg_lp_en && !flash_pd_en && state_o == ST_RUN));

    // R3: busy activity holds the entry pending.
    assert_hold_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PEND && (flash_busy || bus_busy) && !wake_evt) |=> state_o == ST_PEND);

    // R4: the clock is gated while stopped.
    assert_stop_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_STOP) |-> clk_gate);

    // R5: the power controls do not move while stopped.
    assert_stop_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_STOP && !wake_evt) |=> ($stable(reg_lp_en) && $stable(flash_pd_en)));

    // R6: the return pulse follows only a waking cycle.
    assert_pulse_after_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_pulse) |-> (state_o == ST_RUN && $past(state_o) == ST_WAKE));

    // R7: full-power regulator and gated clock while waking.
    assert_wake_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_WAKE) |-> (!reg_lp_en && clk_gate));

    // R8: a wake event while pending cancels the entry without a pulse.
    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PEND && wake_evt) |=> (state_o == ST_RUN && !run_pulse && !clk_gate));

    // R9: the watchdog enable never falls outside reset.
    assert_wdg_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_run |=> wdg_run);

endmodule

bind stop_sequencer stop_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flash_busy  (flash_busy),
    .bus_busy    (bus_busy),
    .wake_evt    (wake_evt),
    .clk_gate    (clk_gate),
    .reg_lp_en   (reg_lp_en),
    .flash_pd_en (flash_pd_en),
    .light_sleep (light_sleep),
    .wdg_run     (wdg_run),
    .state_o     (state_o),
    .run_pulse   (run_pulse)
);

// File: tb/stop_sequencer_tb.sv
// Bench for stop_sequencer: seeded random stop cycles plus directed cases.
module stop_sequencer_tb;

    localparam int REG_C = 5;
    localparam int FLS_C = 7;
    localparam int OSC_C = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, deep_sel = 0, cfg_lp_reg = 0, cfg_flash_pd = 0;
    logic flash_busy = 0, bus_busy = 0, wake_evt = 0, wdg_start = 0;
    logic clk_gate, reg_lp_en, flash_pd_en, light_sleep, wdg_run, run_pulse;
    logic [1:0] state_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int unsigned seed_v;

    always #2 clk = ~clk;

    stop_sequencer #(.REG_CYC(REG_C), .FLASH_CYC(FLS_C), .OSC_CYC(OSC_C)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .deep_sel(deep_sel),
        .cfg_lp_reg(cfg_lp_reg), .cfg_flash_pd(cfg_flash_pd),
        .flash_busy(flash_busy), .bus_busy(bus_busy), .wake_evt(wake_evt),
        .wdg_start(wdg_start), .clk_gate(clk_gate), .reg_lp_en(reg_lp_en),
        .flash_pd_en(flash_pd_en), .light_sleep(light_sleep), .wdg_run(wdg_run),
        .state_o(state_o), .run_pulse(run_pulse)
    );

    function automatic int exp_latency(input bit lp, input bit pd);
        return (lp ? REG_C : 0) + (pd ? FLS_C : 0) + OSC_C;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_idle_run(input string req);
        check(state_o == 2'b00, req, state_o, 0);
        check({clk_gate, reg_lp_en, flash_pd_en, run_pulse} == 4'b0, req,
              {clk_gate, reg_lp_en, flash_pd_en, run_pulse}, 0);
    endtask

    // Full deep-stop cycle with busy hold-off, cfg flips in stop, timed wake.
    task automatic stop_cycle(input bit lp, input bit pd, input int fb, input int bb, input int dwell);
        int hold;
        int n;
        hold = (fb > bb) ? fb : bb;
        if (hold < 1) hold = 1;
        cfg_lp_reg = lp; cfg_flash_pd = pd;
        flash_busy = (fb > 0); bus_busy = (bb > 0);
        sleep_req = 1; deep_sel = 1;
        tick();
        sleep_req = 0;
        for (int i = 0; i < hold; i++) begin
            check(state_o == 2'b01, "R3 pending", state_o, 1);
            flash_busy = (i + 1 < fb);
            bus_busy   = (i + 1 < bb);
            tick();
        end
        check(state_o == 2'b10, "R3 stop reached", state_o, 2);
        check(clk_gate && reg_lp_en == lp && flash_pd_en == pd, "R4 stop outputs",
              {clk_gate, reg_lp_en, flash_pd_en}, {1'b1, lp, pd});
        for (int d = 0; d < dwell; d++) begin
            cfg_lp_reg = $urandom(); cfg_flash_pd = $urandom();
            sleep_req = $urandom();
            tick();
            sleep_req = 0;
            check(state_o == 2'b10 && reg_lp_en == lp && flash_pd_en == pd,
                  "R5 R10 cfg/request ignored in stop", {state_o, reg_lp_en, flash_pd_en},
                  {2'b10, lp, pd});
        end
        wake_evt = 1;
        tick();
        wake_evt = 0;
        n = 0;
        while (state_o == 2'b11 && n < 100) begin
            n++;
            cfg_lp_reg = $urandom(); cfg_flash_pd = $urandom();
            check(!reg_lp_en && clk_gate, "R7 wake outputs", {reg_lp_en, clk_gate}, 1);
            if (lp && pd)
                check(flash_pd_en == (n <= REG_C), "R7 phase order", flash_pd_en, (n <= REG_C));
            tick();
        end
        check(n == exp_latency(lp, pd), "R6 R5 wake latency", n, exp_latency(lp, pd));
        check(run_pulse && state_o == 2'b00 && !clk_gate, "R6 return pulse", run_pulse, 1);
        tick();
        check(!run_pulse, "R6 pulse one cycle", run_pulse, 0);
        cfg_lp_reg = 0; cfg_flash_pd = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        seed_v = $urandom(32'h5EED_0042);
        repeat (3) tick();
        check_idle_run("R1 in reset");
        check(!light_sleep && !wdg_run, "R1 in reset flags", {light_sleep, wdg_run}, 0);
        rst_n = 1;
        tick();
        check_idle_run("R1 after reset");

        // R10: wake event in run does nothing.
        wake_evt = 1; tick(); wake_evt = 0;
        check_idle_run("R10 wake in run");
        check(!light_sleep, "R10 no light sleep", light_sleep, 0);

        // R2: light sleep.
        sleep_req = 1; deep_sel = 0; cfg_lp_reg = 1; cfg_flash_pd = 1; tick(); sleep_req = 0;
        check(light_sleep, "R2 light set", light_sleep, 1);
        check_idle_run("R2 light no power change");
        tick(); tick();
        check(light_sleep, "R2 light held", light_sleep, 1);
        wake_evt = 1; tick(); wake_evt = 0;
        check(!light_sleep, "R2 light cleared", light_sleep, 0);
        check_idle_run("R2 after light wake");
        cfg_lp_reg = 0; cfg_flash_pd = 0;

        // R8: cancel while pending.
        flash_busy = 1; sleep_req = 1; deep_sel = 1; tick(); sleep_req = 0;
        check(state_o == 2'b01, "R8 pending", state_o, 1);
        wake_evt = 1; tick(); wake_evt = 0; flash_busy = 0;
        check_idle_run("R8 cancel");
        tick();
        check_idle_run("R8 stays run");

        // R9: watchdog keep-running.
        wdg_start = 1; tick(); wdg_start = 0;
        check(wdg_run, "R9 set", wdg_run, 1);

        // Directed: every mode with no busy, then bus only, flash only.
        for (int m = 0; m < 4; m++) stop_cycle(m[1], m[0], 0, 0, 1);
        stop_cycle(1, 1, 0, 4, 2);
        stop_cycle(0, 1, 3, 0, 1);

        // Random mixes.
        for (int k = 0; k < 30; k++)
            stop_cycle($urandom_range(1), $urandom_range(1), $urandom_range(5),
                       $urandom_range(5), $urandom_range(1, 4));

        check(wdg_run, "R9 survives stop", wdg_run, 1);
        rst_n = 0; tick(); rst_n = 1; tick();
        check(!wdg_run, "R9 cleared by reset", wdg_run, 0);
        check_idle_run("R1 after second reset");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule